// File: doc/BRIEF.md
# Parallel Quadratic Permutation Address Generator

This block turns one index request into eight interleaver addresses at once. A request names a base index, a block length N and the two polynomial coefficients f1 and f2. Lane i evaluates the quadratic permutation for x = base + i. Eight trellis lanes of a soft-output decoder can therefore read interleaved a-priori values, or write deinterleaved extrinsic values, in the same cycle. The same unit serves both directions; only the role of the returned address changes.

No lane depends on another, so every address is computed in closed form rather than by stepping a running sum. The computation is ordered as ((f2·x mod N) + f1) mod N, which is then multiplied by x and reduced mod N again. Neither product grows beyond twice the index width. The reductions are pipelines of compare-and-subtract steps. The block takes a new request every cycle and answers exactly four cycles later. The coefficients travel with the request, so the configuration may change from one request to the next. The coefficient table for each block size is held outside the block.

Top module: `qpp_addr_gen`

## Requirements
- R1: For each lane i with x = req_base + i below req_len, the lane address at rsp_addr[i*NW +: NW] equals (f1·x + f2·x²) mod N, using the f1, f2 and N sampled with the request. This requires f1 and f2 to be below N.
- R2: rsp_valid rises exactly four clock cycles after a cycle with req_valid high, and is low four cycles after a cycle with req_valid low. Back-to-back requests are each answered in order, one per cycle.
- R3: A lane whose index x = req_base + i is at or above req_len has its bit in rsp_oor set and its address forced to zero. Lanes with x below req_len have their rsp_oor bit clear.
- R4: With the default index width of 13 bits, block lengths up to 6144 give exact results up to the largest index N−1, with no wrap of any intermediate value.
- R5: The block length and both coefficients are captured together with each request. A change of configuration between consecutive requests takes effect for the second request without disturbing the first.
- R6: While rst_n is low, rsp_valid is low, and requests presented during reset produce no response after reset is released.
- R7: Within one response, every in-range lane address is below N. When f1 and f2 form a valid permutation for N, the in-range addresses of the lanes are pairwise distinct.
- R8: Sweeping req_base over 0, 8, 16, … below N with valid coefficients returns every value from 0 to N−1 exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_valid | input | 1 | Request strobe, one request per cycle |
| req_base | input | NW | Index of lane 0; lane i uses req_base + i |
| req_len | input | NW | Block length N |
| req_f1 | input | NW | Linear coefficient f1, below N |
| req_f2 | input | NW | Quadratic coefficient f2, below N |
| rsp_valid | output | 1 | Response strobe, four cycles after the request |
| rsp_addr | output | LANES*NW | Lane addresses, lane i in bits [i*NW +: NW] |
| rsp_oor | output | LANES | Per-lane out-of-range flag, bit i for lane i |

## Verification
The bench builds the block with its defaults: NW = 13 and LANES = 8. This brings the largest block length of 6144 within reach, together with the widest products (index times coefficient near N²) and base indices up to 8191, where every lane is out of range. Full base sweeps over N = 40, 1024 and 6144 check that each address appears exactly once. Random traffic switches among six valid coefficient sets on consecutive cycles, with idle gaps, so that the per-request capture of the configuration and the fixed latency are both tested.

// File: rtl/qpp_pkg.sv
`timescale 1ns/1ps
package qpp_pkg;
  // Number of register stages between a request and its response.
  localparam int unsigned QPP_PIPE_DEPTH = 4;
  // Number of synchronizer flops on reset release.
  localparam int unsigned QPP_RST_SYNC   = 2;
endpackage

// File: rtl/qpp_rst_sync.sv
`timescale 1ns/1ps
module qpp_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/qpp_modred.sv
`timescale 1ns/1ps
// Restoring modular reduction: STEPS compare-and-subtract steps with the
// modulus shifted left by STEPS-1 down to 0. Correct when val_i < mod_i * 2**STEPS.
module qpp_modred #(
  parameter int unsigned VW    = 26,
  parameter int unsigned MW    = 13,
  parameter int unsigned STEPS = 13
) (
  input  logic [VW-1:0] val_i,
  input  logic [MW-1:0] mod_i,
  output logic [MW-1:0] rem_o
);
  logic [VW-1:0] part [STEPS+1];

  assign part[0] = val_i;

  for (genvar j = 0; j < STEPS; j++) begin : g_step
    localparam int unsigned SH = STEPS - 1 - j;
    logic [VW:0] sub_w;
    logic [VW:0] diff_w;
    assign sub_w      = {{(VW + 1 - MW){1'b0}}, mod_i} << SH;
    assign diff_w     = {1'b0, part[j]} - sub_w;
    assign part[j+1]  = diff_w[VW] ? part[j] : diff_w[VW-1:0];
  end

  assign rem_o = part[STEPS][MW-1:0];
endmodule

// File: rtl/qpp_lane.sv
`timescale 1ns/1ps
// One address lane: four register stages.
//   S1: range check, p = f2 * x
//   S2: s = ((p mod N) + f1) mod N
//   S3: q = s * x
//   S4: addr = q mod N (zero when out of range)
module qpp_lane #(
  parameter int unsigned NW = 13
) (
  input  logic          clk,
  input  logic [3:0]    stg_en,
  input  logic [NW:0]   idx_i,
  input  logic [NW-1:0] len_s0,
  input  logic [NW-1:0] f2_s0,
  input  logic [NW-1:0] len_s1,
  input  logic [NW-1:0] f1_s1,
  input  logic [NW-1:0] len_s3,
  output logic [NW-1:0] addr_o,
  output logic          oor_o
);
  localparam int unsigned PW = 2 * NW;

  // Stage 1
  logic          oor1_d, oor1_q;
  logic [NW-1:0] x1_d, x1_q;
  logic [PW-1:0] prod1_d, prod1_q;

  always_comb begin
    oor1_d  = (idx_i >= {1'b0, len_s0});
    x1_d    = oor1_d ? '0 : idx_i[NW-1:0];
    prod1_d = {{NW{1'b0}}, f2_s0} * {{NW{1'b0}}, x1_d};
  end

  always_ff @(posedge clk) begin
    if (stg_en[0]) begin
      oor1_q  <= oor1_d;
      x1_q    <= x1_d;
      prod1_q <= prod1_d;
    end
  end

  // Stage 2
  logic [NW-1:0] rem1_w;
  logic [NW:0]   sum2_w;
  logic [NW-1:0] sum2_d, sum2_q;
  logic [NW-1:0] x2_q;
  logic          oor2_q;

  qpp_modred #(.VW(PW), .MW(NW), .STEPS(NW)) u_red_inner (
    .val_i (prod1_q),
    .mod_i (len_s1),
    .rem_o (rem1_w)
  );

  always_comb begin
    sum2_w = {1'b0, f1_s1} + {1'b0, rem1_w};
  end

  qpp_modred #(.VW(NW + 1), .MW(NW), .STEPS(1)) u_red_sum (
    .val_i (sum2_w),
    .mod_i (len_s1),
    .rem_o (sum2_d)
  );

  always_ff @(posedge clk) begin
    if (stg_en[1]) begin
      sum2_q <= sum2_d;
      x2_q   <= x1_q;
      oor2_q <= oor1_q;
    end
  end

  // Stage 3
  logic [PW-1:0] prod3_d, prod3_q;
  logic          oor3_q;

  always_comb begin
    prod3_d = {{NW{1'b0}}, sum2_q} * {{NW{1'b0}}, x2_q};
  end

  always_ff @(posedge clk) begin
    if (stg_en[2]) begin
      prod3_q <= prod3_d;
      oor3_q  <= oor2_q;
    end
  end

  // Stage 4
  logic [NW-1:0] rem3_w;
  logic [NW-1:0] addr4_d, addr4_q;
  logic          oor4_q;

  qpp_modred #(.VW(PW), .MW(NW), .STEPS(NW)) u_red_outer (
    .val_i (prod3_q),
    .mod_i (len_s3),
    .rem_o (rem3_w)
  );

  always_comb begin
    addr4_d = oor3_q ? '0 : rem3_w;
  end

  always_ff @(posedge clk) begin
    if (stg_en[3]) begin
      addr4_q <= addr4_d;
      oor4_q  <= oor3_q;
    end
  end

  assign addr_o = addr4_q;
  assign oor_o  = oor4_q;
endmodule

// File: rtl/qpp_addr_gen.sv
`timescale 1ns/1ps
module qpp_addr_gen
  import qpp_pkg::*;
#(
  parameter int unsigned NW    = 13,
  parameter int unsigned LANES = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic [NW-1:0]         req_base,
  input  logic [NW-1:0]         req_len,
  input  logic [NW-1:0]         req_f1,
  input  logic [NW-1:0]         req_f2,
  output logic                  rsp_valid,
  output logic [LANES*NW-1:0]   rsp_addr,
  output logic [LANES-1:0]      rsp_oor
);
  localparam int unsigned DEPTH = QPP_PIPE_DEPTH;
  localparam int unsigned XW    = NW + 1;

  logic rst_core_n;

  qpp_rst_sync #(.STAGES(QPP_RST_SYNC)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  // Valid pipeline
  logic [DEPTH-1:0] vld_d, vld_q;

  always_comb begin
    vld_d = {vld_q[DEPTH-2:0], req_valid};
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      vld_q <= '0;
    end else begin
      vld_q <= vld_d;
    end
  end

  // Per-request configuration travelling beside the data
  logic [NW-1:0] len_q1, len_q2, len_q3;
  logic [NW-1:0] f1_q1;

  always_ff @(posedge clk) begin
    if (req_valid) begin
      len_q1 <= req_len;
      f1_q1  <= req_f1;
    end
  end

  always_ff @(posedge clk) begin
    if (vld_q[0]) begin
      len_q2 <= len_q1;
    end
  end

  always_ff @(posedge clk) begin
    if (vld_q[1]) begin
      len_q3 <= len_q2;
    end
  end

  logic [3:0] stg_en;
  assign stg_en = {vld_q[2:0], req_valid};

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [XW-1:0] idx_w;
    assign idx_w = {1'b0, req_base} + XW'(i);

    qpp_lane #(.NW(NW)) u_lane (
      .clk    (clk),
      .stg_en (stg_en),
      .idx_i  (idx_w),
      .len_s0 (req_len),
      .f2_s0  (req_f2),
      .len_s1 (len_q1),
      .f1_s1  (f1_q1),
      .len_s3 (len_q3),
      .addr_o (rsp_addr[i*NW +: NW]),
      .oor_o  (rsp_oor[i])
    );
  end

  assign rsp_valid = vld_q[DEPTH-1];
endmodule

// File: rtl/qpp_addr_gen_chk.sv
`timescale 1ns/1ps
module qpp_addr_gen_chk #(
  parameter int unsigned NW    = 13,
  parameter int unsigned LANES = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic [NW-1:0]       req_base,
  input logic [NW-1:0]       req_len,
  input logic                rsp_valid,
  input logic [LANES*NW-1:0] rsp_addr,
  input logic [LANES-1:0]    rsp_oor
);
  logic [2:0] warm_q;
  logic       warm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warm_q <= '0;
    end else if (warm_q != 3'd4) begin
      warm_q <= warm_q + 3'd1;
    end
  end

  assign warm = (warm_q == 3'd4);

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_idle_R6: assert (!rsp_valid);
    end
  end

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> (rsp_valid == $past(req_valid, 4)));

  for (genvar i = 0; i < LANES; i++) begin : g_lane_chk
    assert_oor_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && rsp_valid) |->
        (rsp_oor[i] == (({1'b0, $past(req_base, 4)} + (NW+1)'(i)) >= {1'b0, $past(req_len, 4)})));

    assert_oor_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_oor[i]) |-> (rsp_addr[i*NW +: NW] == '0));

    assert_addr_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && rsp_valid && !rsp_oor[i]) |-> (rsp_addr[i*NW +: NW] < $past(req_len, 4)));

    for (genvar j = i + 1; j < LANES; j++) begin : g_pair
      assert_distinct_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_oor[i] && !rsp_oor[j]) |->
          (rsp_addr[i*NW +: NW] != rsp_addr[j*NW +: NW]));
    end
  end
endmodule

bind qpp_addr_gen qpp_addr_gen_chk #(.NW(NW), .LANES(LANES)) chk_i (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .req_valid (req_valid),
  .req_base  (req_base),
  .req_len   (req_len),
  .rsp_valid (rsp_valid),
  .rsp_addr  (rsp_addr),
  .rsp_oor   (rsp_oor)
);

// File: tb/qpp_addr_gen_tb_top.sv
`timescale 1ns/1ps
module qpp_addr_gen_tb_top;
  localparam int NW    = 13;
  localparam int LANES = 8;

  logic                clk = 1'b0;
  logic                rst_n;
  logic                req_valid;
  logic [NW-1:0]       req_base, req_len, req_f1, req_f2;
  logic                rsp_valid;
  logic [LANES*NW-1:0] rsp_addr;
  logic [LANES-1:0]    rsp_oor;

  qpp_addr_gen #(.NW(NW), .LANES(LANES)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_base  (req_base),
    .req_len   (req_len),
    .req_f1    (req_f1),
    .req_f2    (req_f2),
    .rsp_valid (rsp_valid),
    .rsp_addr  (rsp_addr),
    .rsp_oor   (rsp_oor)
  );

  always #2.5 clk = ~clk;

  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  typedef struct {
    int     base;
    int     n;
    int     f1;
    int     f2;
    longint due;
    bit     sw;
  } exp_t;

  exp_t pend[$];
  bit   seen [8192];
  int   sweep_dup;

  int tn  [6] = '{40, 48, 56, 64, 1024, 6144};
  int tf1 [6] = '{3, 7, 19, 7, 31, 263};
  int tf2 [6] = '{10, 12, 42, 16, 64, 480};

  function automatic int qpp_ref(int x, int n, int f1, int f2);
    longint xl = x;
    longint v  = (longint'(f1) * xl + longint'(f2) * xl * xl) % longint'(n);
    return int'(v);
  endfunction

  task automatic expect_eq(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic observe();
    if (pend.size() != 0 && pend[0].due == cyc) begin
      exp_t e = pend.pop_front();
      expect_eq("R2 rsp_valid at latency 4", rsp_valid, 1);
      for (int i = 0; i < LANES; i++) begin
        int x   = e.base + i;
        bit oor = (x >= e.n);
        int ea  = oor ? 0 : qpp_ref(x, e.n, e.f1, e.f2);
        int aa  = int'(rsp_addr[i*NW +: NW]);
        expect_eq("R3 out-of-range flag", rsp_oor[i], oor);
        if (oor) expect_eq("R3 forced zero address", aa, 0);
        else if (e.n == 6144) expect_eq("R4 address at N=6144", aa, ea);
        else expect_eq("R1 lane address", aa, ea);
        if (e.sw && !oor) begin
          if (seen[aa]) sweep_dup++;
          seen[aa] = 1'b1;
        end
      end
    end else if (rsp_valid) begin
      expect_eq("R2 no response without request", rsp_valid, 0);
    end
  endtask

  task automatic step(bit v, int base, int n, int f1, int f2, bit sw);
    @(negedge clk);
    observe();
    req_valid = v;
    req_base  = NW'(base);
    req_len   = NW'(n);
    req_f1    = NW'(f1);
    req_f2    = NW'(f2);
    if (v) pend.push_back('{base, n, f1, f2, cyc + 4, sw});
  endtask

  task automatic drain();
    while (pend.size() != 0) step(0, 0, 40, 3, 10, 0);
    repeat (2) step(0, 0, 40, 3, 10, 0);
  endtask

  task automatic sweep(int n, int f1, int f2, bit gaps);
    int cnt = 0;
    for (int a = 0; a < 8192; a++) seen[a] = 1'b0;
    sweep_dup = 0;
    for (int b = 0; b < n; b += 8) begin
      step(1, b, n, f1, f2, 1);
      if (gaps && ($urandom_range(0, 3) == 0)) step(0, 0, n, f1, f2, 0);
    end
    drain();
    for (int a = 0; a < 8192; a++) if (seen[a]) cnt++;
    expect_eq("R8 distinct addresses in sweep", cnt, n);
    expect_eq("R8 duplicates in sweep", sweep_dup, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n     = 1'b0;
    req_valid = 1'b1;
    req_base  = '0;
    req_len   = 13'd40;
    req_f1    = 13'd3;
    req_f2    = 13'd10;

    // R6: reset holds the response idle even with requests applied
    repeat (4) begin
      @(negedge clk);
      expect_eq("R6 rsp_valid in reset", rsp_valid, 0);
    end
    @(negedge clk);
    rst_n     = 1'b1;
    req_valid = 1'b0;
    repeat (8) begin
      @(negedge clk);
      expect_eq("R6 no response from reset-time request", rsp_valid, 0);
    end

    // R1: small directed patterns
    step(1, 0, 40, 3, 10, 0);
    step(1, 8, 40, 3, 10, 0);
    step(0, 0, 40, 3, 10, 0);
    step(1, 16, 48, 7, 12, 0);
    drain();

    // R3: partial and full out-of-range responses
    step(1, 37, 40, 3, 10, 0);
    step(1, 8191, 40, 3, 10, 0);
    step(1, 6140, 6144, 263, 480, 0);
    step(1, 0, 0, 0, 0, 0);
    drain();

    // R4: top of the largest block
    step(1, 6136, 6144, 263, 480, 0);
    step(1, 6128, 6144, 263, 480, 0);
    drain();

    // R5: configuration changes on consecutive cycles
    step(1, 0, 40, 3, 10, 0);
    step(1, 0, 6144, 263, 480, 0);
    step(1, 1000, 1024, 31, 64, 0);
    step(1, 32, 40, 3, 10, 0);
    drain();

    // R8 / R2: full sweeps, back-to-back and with gaps
    sweep(40, 3, 10, 0);
    sweep(1024, 31, 64, 1);
    sweep(6144, 263, 480, 0);

    // R1 / R3 / R5: random mixed traffic
    for (int r = 0; r < 2500; r++) begin
      int k    = $urandom_range(0, 5);
      int base = $urandom_range(0, tn[k] + 8);
      bit v    = ($urandom_range(0, 3) != 0);
      step(v, base, tn[k], tf1[k], tf2[k], 0);
    end
    drain();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule